// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block decides, once per machine cycle, whether a small CPU should be diverted to a service routine and which of six request sources gets the routine. Each source can be routed to a high or a low urgency level. Inside a level, a fixed polling order breaks ties. The arbiter keeps track of which levels are currently being serviced, so that a request can only break into a routine of lower urgency. It also honours the CPU's status: vectoring waits for the last cycle of an instruction, and it waits one more instruction after a return-from-interrupt or after a write to the enable or priority configuration.

Requests are captured into a snapshot at a sampling strobe that arrives once per machine cycle, and the next strobe polls that snapshot. The two external inputs are active low and have their own capture logic, each switchable between edge and level sensing. Software can overwrite the external flags directly. The other four sources (two timers, the serial port and the third timer) arrive as flag levels from outside. The vector output is a single-cycle strobe carrying a source index and a level bit. It has no ready, because the CPU status inputs already hold the CPU's readiness to accept it. The hardware-clear outputs pulse in the same cycle as the strobe.

Top module: `irq_arbiter2`

## Requirements
- R1: Source indices are 0 external-0, 1 timer-0, 2 external-1, 3 timer-1, 4 serial (either of its two flags), 5 timer-2 (either of its two flags). Among pending requests of the same level, the lowest index is vectored first.
- R2: While a low-level routine is active, only a high-level request is vectored. While a high-level routine is active, nothing is vectored.
- R3: A flag present at one sampling strobe is polled at the next strobe. `vec_vld` pulses for one clock after that polling strobe, never after the strobe that sampled it.
- R4: No vector is issued at a strobe where `last_cyc` is low, `ins_reti` is high, or `ins_cfg_wr` is high.
- R5: A request that is held off by R4 and has gone away by the sample taken before the block lifts is never vectored.
- R6: With a vector, `hw_clr` has a one at the vectored index only for timer-0, timer-1, and an external source in edge mode. It has no one for a level-mode external source, the serial source or timer-2. The internal edge-mode external flag is cleared.
- R7: With `ext_edge_mode[k]`=1, flag k is set when a high sample of `ext_pin_n[k]` is followed by a low sample on consecutive strobes, and it stays set until cleared. With `ext_edge_mode[k]`=0, the flag follows the inverted pin at each strobe.
- R8: A source is vectored only when its `src_en` bit and `glob_en` are both high.
- R9: A one-clock pulse on `ext_sw_we[k]` loads `ext_sw_val[k]` into external flag k. A flag set this way is vectored just like one set by the pin, and a flag cleared this way is not vectored.
- R10: A strobe with `ins_reti` and `last_cyc` both high clears the high bit of `act_lvl` if it is set, and otherwise clears the low bit.
- R11: After reset, `vec_vld`, `hw_clr`, `act_lvl` and `ext_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| smp_stb | input | 1 | once-per-machine-cycle sample/poll strobe |
| ext_pin_n | input | 2 | active-low external request pins |
| ext_edge_mode | input | 2 | 1 = edge sensing, 0 = level sensing, per external input |
| ext_sw_we | input | 2 | software write strobe for each external flag |
| ext_sw_val | input | 2 | value written by software |
| tmr_flag | input | 2 | timer-0 and timer-1 overflow flags |
| ser_flag | input | 2 | serial receive and transmit flags |
| t2_flag | input | 2 | timer-2 overflow and external flags |
| src_en | input | 6 | per-source enable, by source index |
| glob_en | input | 1 | global enable |
| src_hi | input | 6 | per-source level, 1 = high |
| last_cyc | input | 1 | current cycle ends the instruction |
| ins_reti | input | 1 | current instruction is a return-from-interrupt |
| ins_cfg_wr | input | 1 | current instruction writes enable or priority config |
| vec_vld | output | 1 | vector request strobe |
| vec_idx | output | 3 | vectored source index |
| vec_hi | output | 1 | vectored level |
| hw_clr | output | 6 | hardware clear pulses by source index |
| ext_flag | output | 2 | external request flags |
| act_lvl | output | 2 | in-service levels, bit 1 high, bit 0 low |

## Verification
The polling order is tested with all four externally flagged sources raised at once and released one at a time. This separates a correct order from a reversed or rotated one, and the same run shows which sources get a hardware clear. Preemption is driven from every nesting state: a low-level request against an active low routine, a high-level request against it, and a high-level request against an active high routine. A return then shows that exactly the top level is released. The blocking inputs are raised one at a time over a standing request, to separate the three gate terms. A request that disappears while held off separates "polls the previous snapshot" from "polls a latched-forever request". The external inputs are driven through a falling edge, a held low level and software writes, which separates edge capture, level following and the software path.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_COUNT = 6;
  localparam int EXT_COUNT = 2;
  localparam int IDX_W     = $clog2(SRC_COUNT);
  localparam int SRC_TMR0  = 1;
  localparam int SRC_TMR1  = 3;
  localparam int SRC_SER   = 4;
  localparam int SRC_T2    = 5;

  function automatic int ext_src(input int k);
    return 2 * k;
  endfunction
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic sw_we,
  input  logic sw_val,
  input  logic hw_clr,
  output logic flag
);
  logic pin_q;
  logic fall;

  assign fall = pin_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      flag  <= 1'b0;
    end else begin
      if (smp_stb) pin_q <= pin_n;
      if (sw_we)
        flag <= sw_val;
      else if (smp_stb)
        flag <= edge_mode ? ((flag & ~hw_clr) | fall) : ~pin_n;
      else if (hw_clr)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 6,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ret_fire,
  input  logic       take_hi,
  input  logic       take_lo,
  output logic [1:0] act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 2'b00;
    end else if (ret_fire) begin
      if (act[1]) act[1] <= 1'b0;
      else        act[0] <= 1'b0;
    end else begin
      if (take_hi) act[1] <= 1'b1;
      if (take_lo) act[0] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_arbiter2.sv
module irq_arbiter2
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic [EXT_COUNT-1:0] ext_pin_n,
  input  logic [EXT_COUNT-1:0] ext_edge_mode,
  input  logic [EXT_COUNT-1:0] ext_sw_we,
  input  logic [EXT_COUNT-1:0] ext_sw_val,
  input  logic [1:0]           tmr_flag,
  input  logic [1:0]           ser_flag,
  input  logic [1:0]           t2_flag,
  input  logic [SRC_COUNT-1:0] src_en,
  input  logic                 glob_en,
  input  logic [SRC_COUNT-1:0] src_hi,
  input  logic                 last_cyc,
  input  logic                 ins_reti,
  input  logic                 ins_cfg_wr,
  output logic                 vec_vld,
  output logic [IDX_W-1:0]     vec_idx,
  output logic                 vec_hi,
  output logic [SRC_COUNT-1:0] hw_clr,
  output logic [EXT_COUNT-1:0] ext_flag,
  output logic [1:0]           act_lvl
);
  logic [SRC_COUNT-1:0] cur, snap, elig, hi_req, lo_req, auto_clr, clr_now;
  logic                 hi_any, lo_any, gate_ok, take_hi, take_lo, ret_fire;
  logic [IDX_W-1:0]     hi_idx, lo_idx, sel_idx;

  // external capture, one per external source
  for (genvar k = 0; k < EXT_COUNT; k++) begin : g_ext
    irq_edge_cap u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_stb  (smp_stb),
      .pin_n    (ext_pin_n[k]),
      .edge_mode(ext_edge_mode[k]),
      .sw_we    (ext_sw_we[k]),
      .sw_val   (ext_sw_val[k]),
      .hw_clr   (clr_now[ext_src(k)]),
      .flag     (ext_flag[k])
    );
  end

  always_comb begin
    cur      = '0;
    auto_clr = '0;
    for (int k = 0; k < EXT_COUNT; k++) begin
      cur[ext_src(k)]      = ext_flag[k];
      auto_clr[ext_src(k)] = ext_edge_mode[k];
    end
    cur[SRC_TMR0]      = tmr_flag[0];
    cur[SRC_TMR1]      = tmr_flag[1];
    cur[SRC_SER]       = |ser_flag;
    cur[SRC_T2]        = |t2_flag;
    auto_clr[SRC_TMR0] = 1'b1;
    auto_clr[SRC_TMR1] = 1'b1;
  end

  // polling works on the snapshot taken at the previous strobe
  assign elig   = snap & src_en & {SRC_COUNT{glob_en}};
  assign hi_req = elig & src_hi;
  assign lo_req = elig & ~src_hi;

  irq_pick #(.N(SRC_COUNT), .W(IDX_W)) u_pick_hi (.req(hi_req), .any(hi_any), .idx(hi_idx));
  irq_pick #(.N(SRC_COUNT), .W(IDX_W)) u_pick_lo (.req(lo_req), .any(lo_any), .idx(lo_idx));

  assign gate_ok  = smp_stb & last_cyc & ~ins_reti & ~ins_cfg_wr;
  assign take_hi  = gate_ok & hi_any & ~act_lvl[1];
  assign take_lo  = gate_ok & ~take_hi & lo_any & ~act_lvl[1] & ~act_lvl[0];
  assign ret_fire = smp_stb & last_cyc & ins_reti;
  assign sel_idx  = take_hi ? hi_idx : lo_idx;

  always_comb begin
    clr_now = '0;
    if (take_hi || take_lo) clr_now[sel_idx] = auto_clr[sel_idx];
  end

  irq_nest u_nest (
    .clk     (clk),
    .rst_n   (rst_n),
    .ret_fire(ret_fire),
    .take_hi (take_hi),
    .take_lo (take_lo),
    .act     (act_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap    <= '0;
      vec_vld <= 1'b0;
      vec_idx <= '0;
      vec_hi  <= 1'b0;
      hw_clr  <= '0;
    end else begin
      if (smp_stb) snap <= cur & ~clr_now;
      vec_vld <= take_hi | take_lo;
      hw_clr  <= clr_now;
      if (take_hi || take_lo) begin
        vec_idx <= sel_idx;
        vec_hi  <= take_hi;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter2_chk.sv
module irq_arbiter2_chk
  import irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic                 glob_en,
  input logic                 last_cyc,
  input logic                 ins_reti,
  input logic                 ins_cfg_wr,
  input logic                 vec_vld,
  input logic [IDX_W-1:0]     vec_idx,
  input logic                 vec_hi,
  input logic [SRC_COUNT-1:0] hw_clr,
  input logic [1:0]           act_lvl
);
  // R4
  a_r4_blocked_no_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_cyc || ins_reti || ins_cfg_wr) |=> !vec_vld);
  // R2
  a_r2_high_not_preempted: assert property (@(posedge clk) disable iff (!rst_n)
    act_lvl[1] |=> !vec_vld);
  // R2
  a_r2_low_only_by_high: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lvl == 2'b01) |=> (!vec_vld || vec_hi));
  // R8
  a_r8_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !vec_vld);
  // R6
  a_r6_clr_needs_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr != '0) |-> vec_vld);
  // R6
  a_r6_sw_sources_kept: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> (!hw_clr[SRC_SER] && !hw_clr[SRC_T2]));
  // R6
  a_r6_timer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_vld && (vec_idx == IDX_W'(SRC_TMR0))) |-> hw_clr[SRC_TMR0]);
  // R10
  a_r10_ret_drops_high: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && last_cyc && ins_reti && act_lvl == 2'b11) |=> (act_lvl == 2'b01));
  // R6
  a_r6_onehot_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hw_clr));
endmodule

bind irq_arbiter2 irq_arbiter2_chk u_chk (.*);

// File: tb/test_irq_arbiter2.sv
module test_irq_arbiter2;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_stb = 1'b0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge_mode = 2'b11, ext_sw_we = 2'b00, ext_sw_val = 2'b00;
  logic [1:0] tmr_flag = 2'b00, ser_flag = 2'b00, t2_flag = 2'b00;
  logic [5:0] src_en = 6'h3f, src_hi = 6'h00;
  logic       glob_en = 1'b1, last_cyc = 1'b1, ins_reti = 1'b0, ins_cfg_wr = 1'b0;
  logic       vec_vld, vec_hi;
  logic [2:0] vec_idx;
  logic [5:0] hw_clr;
  logic [1:0] ext_flag, act_lvl;

  logic       g_vld, g_hi;
  logic [2:0] g_idx;
  logic [5:0] g_clr;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_arbiter2 i_irq_arbiter2 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_stb = 1'b0;
    ext_pin_n = 2'b11; ext_edge_mode = 2'b11; ext_sw_we = 2'b00; ext_sw_val = 2'b00;
    tmr_flag = 2'b00; ser_flag = 2'b00; t2_flag = 2'b00;
    src_en = 6'h3f; src_hi = 6'h00; glob_en = 1'b1;
    last_cyc = 1'b1; ins_reti = 1'b0; ins_cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one machine cycle: strobe for one clock, capture outputs after the strobe edge
  task automatic tick();
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    g_vld = vec_vld; g_idx = vec_idx; g_hi = vec_hi; g_clr = hw_clr;
    repeat (2) @(negedge clk);
  endtask

  task automatic reti();
    ins_reti = 1'b1; tick(); ins_reti = 1'b0;
  endtask

  task automatic sw_write(input logic [1:0] we, input logic [1:0] val);
    @(negedge clk); ext_sw_we = we; ext_sw_val = val;
    @(negedge clk); ext_sw_we = 2'b00;
  endtask

  task automatic t_reset();
    do_reset();
    chk(vec_vld == 0 && hw_clr == 0, "R11 vec/clr idle", {hw_clr, vec_vld}, 0);
    chk(act_lvl == 0, "R11 act_lvl", act_lvl, 0);
    chk(ext_flag == 0, "R11 ext_flag", ext_flag, 0);
  endtask

  task automatic t_order();
    do_reset();
    tmr_flag = 2'b11; ser_flag = 2'b01; t2_flag = 2'b01;
    tick();
    chk(!g_vld, "R3 no vector on sampling strobe", g_vld, 0);
    tick();
    chk(g_vld && g_idx == 1 && !g_hi, "R1 timer-0 first", g_idx, 1);
    chk(g_clr == 6'b000010, "R6 timer-0 cleared", g_clr, 2);
    chk(act_lvl == 2'b01, "R10 low level active", act_lvl, 1);
    tmr_flag[0] = 1'b0;
    reti();
    chk(act_lvl == 2'b00, "R10 ret releases low", act_lvl, 0);
    tick();
    chk(g_vld && g_idx == 3, "R1 timer-1 second", g_idx, 3);
    chk(g_clr == 6'b001000, "R6 timer-1 cleared", g_clr, 8);
    tmr_flag[1] = 1'b0;
    reti();
    tick();
    chk(g_vld && g_idx == 4, "R1 serial third", g_idx, 4);
    chk(g_clr == 0, "R6 serial not cleared", g_clr, 0);
    ser_flag = 2'b00;
    reti();
    tick();
    chk(g_vld && g_idx == 5 && g_clr == 0, "R1 timer-2 last, not cleared", g_idx, 5);
    do_reset();
    src_hi = 6'h3f; tmr_flag[1] = 1'b1; t2_flag = 2'b10;
    tick(); tick();
    chk(g_vld && g_idx == 3 && g_hi, "R1 order within high level", g_idx, 3);
  endtask

  task automatic t_preempt();
    do_reset();
    tmr_flag[1] = 1'b1;
    tick(); tick();
    chk(g_vld && g_idx == 3 && !g_hi, "R2 low vector", g_idx, 3);
    tmr_flag[1] = 1'b0; tmr_flag[0] = 1'b1;
    tick(); tick();
    chk(!g_vld, "R2 low cannot preempt low", g_vld, 0);
    src_hi[1] = 1'b1;
    tick();
    chk(g_vld && g_idx == 1 && g_hi, "R2 high preempts low", g_idx, 1);
    chk(act_lvl == 2'b11, "R2 both levels active", act_lvl, 3);
    tmr_flag[0] = 1'b0; ser_flag = 2'b10; src_hi[4] = 1'b1;
    tick(); tick();
    chk(!g_vld, "R2 high cannot be preempted", g_vld, 0);
    reti();
    chk(!g_vld && act_lvl == 2'b01, "R10 ret releases high only", act_lvl, 1);
    tick();
    chk(g_vld && g_idx == 4 && g_hi, "R2 high after ret", g_idx, 4);
  endtask

  task automatic t_block();
    do_reset();
    tmr_flag[0] = 1'b1; last_cyc = 1'b0;
    tick(); tick();
    chk(!g_vld, "R4 not last cycle", g_vld, 0);
    last_cyc = 1'b1; ins_reti = 1'b1;
    tick();
    chk(!g_vld, "R4 ret instruction", g_vld, 0);
    ins_reti = 1'b0; ins_cfg_wr = 1'b1;
    tick();
    chk(!g_vld, "R4 config write", g_vld, 0);
    ins_cfg_wr = 1'b0;
    tick();
    chk(g_vld && g_idx == 1, "R4 unblocked vector", g_idx, 1);
    do_reset();
    tmr_flag[1] = 1'b1; last_cyc = 1'b0;
    tick(); tick();
    tmr_flag[1] = 1'b0;
    tick();
    last_cyc = 1'b1;
    tick();
    chk(!g_vld, "R5 dropped request lost", g_vld, 0);
    tick();
    chk(!g_vld, "R5 still lost", g_vld, 0);
  endtask

  task automatic t_enable();
    do_reset();
    src_en[1] = 1'b0; tmr_flag[0] = 1'b1;
    tick(); tick();
    chk(!g_vld, "R8 source disabled", g_vld, 0);
    src_en = 6'h3f; glob_en = 1'b0;
    tick();
    chk(!g_vld, "R8 global disabled", g_vld, 0);
    glob_en = 1'b1;
    tick();
    chk(g_vld && g_idx == 1, "R8 enabled vector", g_idx, 1);
  endtask

  task automatic t_ext();
    do_reset();
    tick();
    ext_pin_n[0] = 1'b0;
    tick();
    chk(ext_flag[0], "R7 edge sets flag", ext_flag[0], 1);
    tick(); tick();
    chk(g_vld && g_idx == 0, "R7 edge source vectored", g_idx, 0);
    chk(g_clr == 6'b000001 && !ext_flag[0], "R6 edge flag cleared", {g_clr, ext_flag[0]}, 2);
    reti(); tick(); tick();
    chk(!g_vld && !ext_flag[0], "R7 held low does not re-set edge flag", ext_flag[0], 0);
    do_reset();
    ext_edge_mode = 2'b01; ext_pin_n[1] = 1'b0;
    tick();
    chk(ext_flag[1], "R7 level follows pin", ext_flag[1], 1);
    tick(); tick();
    chk(g_vld && g_idx == 2 && g_clr == 0, "R6 level source not cleared", g_clr, 0);
    chk(ext_flag[1], "R6 level flag kept", ext_flag[1], 1);
    ext_pin_n[1] = 1'b1;
    tick();
    chk(!ext_flag[1], "R7 level drops with pin", ext_flag[1], 0);
  endtask

  task automatic t_sw();
    do_reset();
    sw_write(2'b01, 2'b01);
    chk(ext_flag[0], "R9 software set", ext_flag[0], 1);
    tick(); tick();
    chk(g_vld && g_idx == 0, "R9 software flag vectored", g_idx, 0);
    reti();
    sw_write(2'b01, 2'b01);
    sw_write(2'b01, 2'b00);
    tick(); tick();
    chk(!g_vld && !ext_flag[0], "R9 software clear cancels", g_vld, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_preempt();
    t_block();
    t_enable();
    t_ext();
    t_sw();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule